// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block sits in the fetch path of a 32-bit integer core. It decodes one instruction word against the current program counter and two register operand values. For conditional branches, the direct jump and the register-indirect jump, it produces the next PC, a taken indication, a link-register write request carrying PC+4, and a flag for malformed encodings. Every other instruction advances to PC+4.

The program counter register lives inside the block. It has three behaviours. Reset loads a parameterised reset vector. Advance, when `adv_en` is high, loads the computed next PC. Hold, when `adv_en` is low, keeps the value. The register file, fetch, pipelining and alignment faults belong to the surrounding core.

Top module: `nxpc_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes `RESET_VEC` (synchronous reset).
- R2: With `rst` low, a rising edge with `adv_en` high loads `pc_next` into `pc_q`. With `adv_en` low, `pc_q` keeps its value.
- R3: Branch opcode 1100011 with funct3 000 is taken when `rs1_val == rs2_val`. With funct3 001 it is taken when they differ.
- R4: Branch funct3 100 is taken when `rs1_val < rs2_val` as two's-complement numbers. Funct3 101 is taken when `rs1_val >= rs2_val` as two's-complement numbers.
- R5: Branch funct3 110 is taken on unsigned less-than. Funct3 111 is taken on unsigned greater-or-equal.
- R6: A taken branch sets `pc_next = pc_q + offset`. The offset has bit 0 = 0, bits 4:1 = instr[11:8], bits 10:5 = instr[30:25], bit 11 = instr[7] and bit 12 = instr[31], and is sign-extended from bit 12. A branch that is not taken gives `pc_q + 4`. A branch never requests a link write.
- R7: Opcode 1101111 is always taken with `pc_next = pc_q + offset`. The offset has bit 0 = 0, bits 10:1 = instr[30:21], bit 11 = instr[20], bits 19:12 = instr[19:12] and bit 20 = instr[31], and is sign-extended from bit 20.
- R8: Opcode 1100111 with funct3 000 is always taken. It gives `pc_next = (rs1_val + sext(instr[31:20]))` with bit 0 forced to 0.
- R9: Both jumps drive `link_data = pc_q + 4` and raise `link_we` only when rd (instr[11:7]) is non-zero.
- R10: Branch funct3 010 or 011, or opcode 1100111 with funct3 other than 000, raise `illegal`. They also give `pc_next = pc_q + 4`, `taken` low and `link_we` low.
- R11: Any other opcode gives `pc_next = pc_q + 4`, with `taken`, `link_we` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Load next PC into the PC register |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Computed next program counter |
| taken | output | 1 | Control transfer redirects the flow |
| link_we | output | 1 | Request to write the link value to rd |
| link_data | output | 32 | Link value, PC+4 |
| illegal | output | 1 | Malformed control-transfer encoding |

## Verification
The only state is the PC register. A wrong value there shows on `pc_q` immediately after the edge that loaded it. It also skews `pc_next` and `link_data` in the same cycle, because both are computed from it. A mis-scrambled immediate or a wrong comparison shows only as a wrong `pc_next` or `taken` for that one instruction, so each funct3 code is checked with operands on both sides of its decision. Offsets are chosen at both sign extremes so that each scattered bit is exercised. After a jump advances the register, the following instruction shows whether the wrong target was committed.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    localparam int ILEN = 32;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    typedef enum logic [1:0] {
        XFER_NONE,
        XFER_COND,
        XFER_DIRECT,
        XFER_INDIRECT
    } xfer_kind_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'b000,
        CMP_NE  = 3'b001,
        CMP_LT  = 3'b100,
        CMP_GE  = 3'b101,
        CMP_LTU = 3'b110,
        CMP_GEU = 3'b111
    } cmp_op_e;

    typedef struct packed {
        xfer_kind_e        kind;
        cmp_op_e           cmp;
        logic              bad;
        logic              link;
        logic [ILEN-1:0]   imm;
    } xfer_dec_t;

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output xfer_dec_t       dec
);

    localparam int B_IMM_W = 13;
    localparam int J_IMM_W = 21;
    localparam int I_IMM_W = 12;

    logic [6:0]          opcode;
    logic [2:0]          funct3;
    logic [4:0]          rd_idx;
    logic [B_IMM_W-1:0]  b_raw;
    logic [J_IMM_W-1:0]  j_raw;
    logic [I_IMM_W-1:0]  i_raw;

    assign opcode = instr[6:0];
    assign funct3 = instr[14:12];
    assign rd_idx = instr[11:7];

    // Reassemble the scattered offsets; bit 0 is always zero.
    assign b_raw = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    assign j_raw = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
    assign i_raw = instr[31:20];

    always_comb begin
        dec      = '0;
        dec.kind = XFER_NONE;
        dec.cmp  = CMP_EQ;
        unique case (opcode)
            OPC_BRANCH: begin
                dec.imm = {{(ILEN-B_IMM_W){b_raw[B_IMM_W-1]}}, b_raw};
                unique case (funct3)
                    3'b000: begin dec.kind = XFER_COND; dec.cmp = CMP_EQ;  end
                    3'b001: begin dec.kind = XFER_COND; dec.cmp = CMP_NE;  end
                    3'b100: begin dec.kind = XFER_COND; dec.cmp = CMP_LT;  end
                    3'b101: begin dec.kind = XFER_COND; dec.cmp = CMP_GE;  end
                    3'b110: begin dec.kind = XFER_COND; dec.cmp = CMP_LTU; end
                    3'b111: begin dec.kind = XFER_COND; dec.cmp = CMP_GEU; end
                    default: dec.bad = 1'b1;
                endcase
            end
            OPC_JAL: begin
                dec.imm  = {{(ILEN-J_IMM_W){j_raw[J_IMM_W-1]}}, j_raw};
                dec.kind = XFER_DIRECT;
                dec.link = (rd_idx != 5'd0);
            end
            OPC_JALR: begin
                dec.imm = {{(ILEN-I_IMM_W){i_raw[I_IMM_W-1]}}, i_raw};
                if (funct3 == 3'b000) begin
                    dec.kind = XFER_INDIRECT;
                    dec.link = (rd_idx != 5'd0);
                end else begin
                    dec.bad = 1'b1;
                end
            end
            default: dec.kind = XFER_NONE;
        endcase
    end

endmodule

// File: rtl/nxpc_cmp.sv
module nxpc_cmp
    import nxpc_pkg::*;
#(
    parameter int W = 32
) (
    input  cmp_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit
);

    logic is_eq;
    logic is_lt_s;
    logic is_lt_u;

    assign is_eq   = (a == b);
    assign is_lt_s = ($signed(a) < $signed(b));
    assign is_lt_u = (a < b);

    always_comb begin
        unique case (op)
            CMP_EQ:  hit = is_eq;
            CMP_NE:  hit = !is_eq;
            CMP_LT:  hit = is_lt_s;
            CMP_GE:  hit = !is_lt_s;
            CMP_LTU: hit = is_lt_u;
            CMP_GEU: hit = !is_lt_u;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
    import nxpc_pkg::*;
#(
    parameter int W = 32
) (
    input  xfer_kind_e   kind,
    input  logic         cond,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] base,
    input  logic [W-1:0] imm,
    output logic [W-1:0] seq_pc,
    output logic [W-1:0] nxt_pc,
    output logic         redirect
);

    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] rel_tgt;
    logic [W-1:0] reg_sum;

    assign seq_pc  = pc + STEP;
    assign rel_tgt = pc + imm;
    assign reg_sum = base + imm;

    always_comb begin
        redirect = 1'b0;
        nxt_pc   = seq_pc;
        unique case (kind)
            XFER_COND: begin
                redirect = cond;
                if (cond) nxt_pc = rel_tgt;
            end
            XFER_DIRECT: begin
                redirect = 1'b1;
                nxt_pc   = rel_tgt;
            end
            XFER_INDIRECT: begin
                redirect = 1'b1;
                nxt_pc   = {reg_sum[W-1:1], 1'b0};
            end
            default: begin
                redirect = 1'b0;
                nxt_pc   = seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/nxpc_top.sv
module nxpc_top
    import nxpc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv_en,
    input  logic [31:0] instr,
    input  logic [31:0] rs1_val,
    input  logic [31:0] rs2_val,
    output logic [31:0] pc_q,
    output logic [31:0] pc_next,
    output logic        taken,
    output logic        link_we,
    output logic [31:0] link_data,
    output logic        illegal
);

    localparam int XLEN = ILEN;

    xfer_dec_t  dec;
    logic       cond_hit;
    logic [XLEN-1:0] seq_pc;

    nxpc_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    nxpc_cmp #(.W(XLEN)) u_cmp (
        .op  (dec.cmp),
        .a   (rs1_val),
        .b   (rs2_val),
        .hit (cond_hit)
    );

    nxpc_target #(.W(XLEN)) u_target (
        .kind     (dec.kind),
        .cond     (cond_hit),
        .pc       (pc_q),
        .base     (rs1_val),
        .imm      (dec.imm),
        .seq_pc   (seq_pc),
        .nxt_pc   (pc_next),
        .redirect (taken)
    );

    assign link_we   = dec.link;
    assign link_data = seq_pc;
    assign illegal   = dec.bad;

    // PC register: reset, advance or hold.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_VEC;
        end else if (adv_en) begin
            pc_q <= pc_next;
        end
    end

    a_r1_reset_vec: assert property (@(posedge clk)
        $past(rst) |-> pc_q == RESET_VEC);

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        adv_en |=> pc_q == $past(pc_next));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> pc_q == $past(pc_q));

    a_r8_jalr_even: assert property (@(posedge clk) disable iff (rst)
        (instr[6:0] == OPC_JALR && !illegal) |-> pc_next[0] == 1'b0);

    a_r9_x0_no_link: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (instr[11:7] != 5'd0 && taken));

    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!taken && !link_we && pc_next == pc_q + 32'd4));

    a_r11_sequential: assert property (@(posedge clk) disable iff (rst)
        !taken |-> pc_next == pc_q + 32'd4);

endmodule

// File: tb/nxpc_top_tb_top.sv
module nxpc_top_tb_top;

    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_en = 1'b0;
    logic [31:0] instr = 32'h0000_0013;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [31:0] pc_q, pc_next, link_data;
    logic        taken, link_we, illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    nxpc_top #(.RESET_VEC(RV)) dut_i (
        .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .pc_q(pc_q),
        .pc_next(pc_next), .taken(taken), .link_we(link_we),
        .link_data(link_data), .illegal(illegal)
    );

    function automatic logic [31:0] enc_b(input logic [2:0] f3, input logic [12:0] im);
        return {im[12], im[10:5], 5'd2, 5'd1, f3, im[4:1], im[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(input logic [4:0] rd, input logic [20:0] im);
        return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_i(input logic [4:0] rd, input logic [2:0] f3, input logic [11:0] im);
        return {im, 5'd1, f3, rd, 7'b1100111};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] nxt, input logic tk,
                         input logic we, input logic ill);
        @(negedge clk);
        instr = ins; rs1_val = a; rs2_val = b;
        #1;
        chk(req, "pc_next", pc_next, nxt);
        chk(req, "taken", {31'd0, taken}, {31'd0, tk});
        chk(req, "link_we", {31'd0, link_we}, {31'd0, we});
        chk(req, "illegal", {31'd0, illegal}, {31'd0, ill});
        if (!ill && (ins[6:0] == 7'b1101111 || ins[6:0] == 7'b1100111))
            chk(req, "link_data", link_data, exp_pc + 32'd4);
    endtask

    task automatic advance(input string req);
        logic [31:0] tgt;
        @(negedge clk);
        tgt = pc_next;
        adv_en = 1'b1;
        @(negedge clk);
        adv_en = 1'b0;
        exp_pc = tgt;
        #1;
        chk(req, "pc_q after advance", pc_q, exp_pc);
    endtask

    task automatic t_reset();
        exp_pc = RV;
        chk("R1", "pc_q after reset", pc_q, RV);
    endtask

    task automatic t_equality();
        probe("R3", enc_b(3'b000, -13'sd8), 32'h55, 32'h55, exp_pc - 32'd8, 1, 0, 0);
        probe("R3", enc_b(3'b000, -13'sd8), 32'h55, 32'h54, exp_pc + 32'd4, 0, 0, 0);
        probe("R3", enc_b(3'b001, 13'd16), 32'h1, 32'h2, exp_pc + 32'd16, 1, 0, 0);
        probe("R3", enc_b(3'b001, 13'd16), 32'h7, 32'h7, exp_pc + 32'd4, 0, 0, 0);
    endtask

    task automatic t_signed();
        probe("R4", enc_b(3'b100, 13'd32), 32'hFFFF_FFFF, 32'h1, exp_pc + 32'd32, 1, 0, 0);
        probe("R4", enc_b(3'b100, 13'd32), 32'h1, 32'hFFFF_FFFF, exp_pc + 32'd4, 0, 0, 0);
        probe("R4", enc_b(3'b101, 13'd32), 32'h5, 32'h5, exp_pc + 32'd32, 1, 0, 0);
        probe("R4", enc_b(3'b101, 13'd32), 32'h8000_0000, 32'h0, exp_pc + 32'd4, 0, 0, 0);
    endtask

    task automatic t_unsigned();
        probe("R5", enc_b(3'b110, 13'd64), 32'hFFFF_FFFF, 32'h1, exp_pc + 32'd4, 0, 0, 0);
        probe("R5", enc_b(3'b110, 13'd64), 32'h1, 32'hFFFF_FFFF, exp_pc + 32'd64, 1, 0, 0);
        probe("R5", enc_b(3'b111, 13'd64), 32'h8000_0000, 32'h0, exp_pc + 32'd64, 1, 0, 0);
        probe("R5", enc_b(3'b111, 13'd64), 32'h3, 32'h4, exp_pc + 32'd4, 0, 0, 0);
    endtask

    task automatic t_branch_offsets();
        probe("R6", enc_b(3'b000, 13'h0FFE), 32'h0, 32'h0, exp_pc + 32'd4094, 1, 0, 0);
        probe("R6", enc_b(3'b000, 13'h1000), 32'h0, 32'h0, exp_pc - 32'd4096, 1, 0, 0);
        probe("R6", enc_b(3'b000, 13'h0802), 32'h0, 32'h0, exp_pc + 32'h802, 1, 0, 0);
    endtask

    task automatic t_jal();
        probe("R7", enc_j(5'd1, 21'h0_FFFFE), 32'h0, 32'h0, exp_pc + 32'h000F_FFFE, 1, 1, 0);
        probe("R7", enc_j(5'd1, 21'h10_0000), 32'h0, 32'h0, exp_pc - 32'h0010_0000, 1, 1, 0);
        probe("R7", enc_j(5'd5, 21'h0_0800), 32'h0, 32'h0, exp_pc + 32'h800, 1, 1, 0);
        probe("R7", enc_j(5'd3, 21'h0_1000), 32'h0, 32'h0, exp_pc + 32'h1000, 1, 1, 0);
        advance("R7");
    endtask

    task automatic t_jalr();
        probe("R8", enc_i(5'd1, 3'b000, 12'hFFF), 32'h0000_2001, 32'h0, 32'h0000_2000, 1, 1, 0);
        probe("R8", enc_i(5'd1, 3'b000, 12'h005), 32'h0000_3000, 32'h0, 32'h0000_3004, 1, 1, 0);
        probe("R8", enc_i(5'd1, 3'b000, 12'h800), 32'h0000_4000, 32'h0, 32'h0000_3800, 1, 1, 0);
        probe("R9", enc_i(5'd0, 3'b000, 12'h000), 32'h0000_5000, 32'h0, 32'h0000_5000, 1, 0, 0);
        probe("R9", enc_j(5'd0, 21'd8), 32'h0, 32'h0, exp_pc + 32'd8, 1, 0, 0);
        advance("R8");
    endtask

    task automatic t_illegal();
        probe("R10", enc_b(3'b010, 13'd8), 32'h1, 32'h1, exp_pc + 32'd4, 0, 0, 1);
        probe("R10", enc_b(3'b011, 13'd8), 32'h1, 32'h2, exp_pc + 32'd4, 0, 0, 1);
        probe("R10", enc_i(5'd1, 3'b001, 12'd8), 32'h100, 32'h0, exp_pc + 32'd4, 0, 0, 1);
    endtask

    task automatic t_other();
        probe("R11", 32'h0010_0093, 32'h1, 32'h1, exp_pc + 32'd4, 0, 0, 0);
        probe("R11", 32'h0000_0017, 32'h0, 32'h0, exp_pc + 32'd4, 0, 0, 0);
    endtask

    task automatic t_hold_advance();
        probe("R2", enc_b(3'b000, 13'd12), 32'h0, 32'h0, exp_pc + 32'd12, 1, 0, 0);
        repeat (3) @(negedge clk);
        #1;
        chk("R2", "pc_q hold", pc_q, exp_pc);
        advance("R2");
        probe("R2", 32'h0000_0013, 32'h0, 32'h0, exp_pc + 32'd4, 0, 0, 0);
        advance("R2");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_equality();
        t_signed();
        t_unsigned();
        t_branch_offsets();
        t_jal();
        t_jalr();
        t_illegal();
        t_other();
        t_hold_advance();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "pc_q after second reset", pc_q, RV);
        finish_run();
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule